// File: doc/BRIEF.md
# Frame Buffer Streaming Reader

This block keeps a display pipeline fed with a stored video frame. It walks a frame held in external memory one 64-bit word per read. Each frame starts at a programmable byte base address, and the address steps by 8 bytes for each word. The words leave as a valid/ready stream in raster order, with the top-left word first. The first word of each frame is marked as start of frame and the last word as end of frame. After the last word the block starts the same frame again from its base, so the picture is refreshed without software help.

The memory side is a simple read master. It raises a request with an address and holds both while the memory answers with wait. Read data comes back in request order, some cycles later, qualified by a valid strobe. The memory can stall for long periods, for example during refresh or arbitration. To cope with this, the block caps the reads in flight plus the words already buffered at its internal buffer depth. Returning data therefore always has room, even while the consumer holds ready low.

Base address and frame length are read once at the start of each frame, so changes written during a frame apply from the next one. Streaming starts only when the enable input is high.

Top module: `fbr_reader`

## Requirements
- R1: After reset, and whenever enable is low with no request stalled by wait, `mem_req` is 0; right after reset `out_valid` is 0.
- R2: The n-th word of a frame (n from 0) is read from byte address base + 8·n. After word length−1 the next read is at the base again.
- R3: `out_sop` is 1 on word 0 of every frame and 0 on all other words. `out_eop` is 1 on word length−1 and 0 on all other words.
- R4: Every word returned by memory leaves on the stream exactly once and in request order, whatever the pattern of wait and ready.
- R5: Reads in flight plus words buffered never exceed DEPTH. With ready held low from reset and wait low, exactly DEPTH reads are accepted.
- R6: Base and length written during a frame leave the rest of that frame unchanged. They take effect from the next word 0.
- R7: While `mem_req` is 1 and `mem_wait` is 1, the next cycle still shows `mem_req` = 1 and the same `mem_addr`.
- R8: While `out_valid` is 1 and `out_ready` is 0, the next cycle shows `out_valid` = 1 and the same data and markers.
- R9: When enable falls with no stalled request, no further read is accepted. Reads already in flight are still delivered, and raising enable again continues from the next address in sequence.
- R10: A frame length of 0 acts as 1: every word is read from the base with both markers set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Allows new reads to be issued |
| cfg_base | input | AW | Frame base byte address, sampled at word 0 |
| cfg_words | input | LW | Frame length in 64-bit words, sampled at word 0 |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read byte address |
| mem_wait | input | 1 | Memory not yet accepting the request |
| mem_rdvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | DW | Stream word |
| out_sop | output | 1 | First word of a frame |
| out_eop | output | 1 | Last word of a frame |

## Verification
The assertions rely on the memory behaving in order. It never returns data for a read it has not accepted, and it returns exactly one word per accepted read. The bench meets this with a fixed-latency memory model that queues accepted addresses and answers them in the same order, and it clears that queue on reset. The frame length stays at or below 2^LW − 1 and the address stays inside AW bits. The bench changes configuration only while the read side is clearly in the middle of a frame, so the frame in which a change applies is unambiguous.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef struct packed {
    logic sop;
    logic eop;
  } fbr_mark_t;

  // byte address of word idx within a frame of 64-bit words
  function automatic logic [63:0] fbr_word_addr(input logic [63:0] base,
                                                input logic [63:0] idx);
    return base + (idx << 3);
  endfunction

  // a programmed length of zero is read as a single-word frame
  function automatic logic [31:0] fbr_frame_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

endpackage

// File: rtl/fbr_fifo.sv
module fbr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign dout  = store[rd_ptr];
  assign empty = (fill == '0);
  assign full  = (fill == CW'(DEPTH));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/fbr_credit.sv
module fbr_credit #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic                       give,
  output logic                       room,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CW = $clog2(DEPTH + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      case ({take, give})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign room = (level < CW'(DEPTH));

  // R5
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R5
  no_return_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> (level != '0));

endmodule

// File: rtl/fbr_addr_gen.sv
module fbr_addr_gen
  import fbr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wait_in,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_words,
  output logic [AW-1:0] addr,
  output fbr_mark_t     mark,
  output logic          hold
);
  logic [LW-1:0] idx;
  logic [LW-1:0] cur_len;
  logic [AW-1:0] cur_base;
  logic          hold_q;

  logic          at_start, use_cfg, step, last;
  logic [AW-1:0] eff_base;
  logic [LW-1:0] eff_len;

  assign at_start = (idx == '0);
  assign use_cfg  = at_start && !hold_q;
  assign step     = req && !wait_in;

  always_comb begin
    eff_base = use_cfg ? cfg_base : cur_base;
    eff_len  = use_cfg ? LW'(fbr_frame_len(32'(cfg_words))) : cur_len;
    last     = (idx == eff_len - LW'(1));
    addr     = AW'(fbr_word_addr(64'(eff_base), 64'(idx)));
    mark.sop = at_start;
    mark.eop = last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      cur_len  <= '0;
      cur_base <= '0;
      hold_q   <= 1'b0;
    end else begin
      hold_q <= req && wait_in;
      if (use_cfg) begin
        cur_base <= cfg_base;
        cur_len  <= eff_len;
      end
      if (step) idx <= last ? '0 : idx + 1'b1;
    end
  end

  assign hold = hold_q;

  // R2
  idx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |-> (idx < cur_len));
  // R6
  base_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_start |=> $stable(cur_base) && $stable(cur_len));

endmodule

// File: rtl/fbr_reader.sv
module fbr_reader
  import fbr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int LW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_words,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_wait,
  input  logic          mem_rdvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int MW = $bits(fbr_mark_t);
  localparam int BW = DW + MW;

  // named events
  logic          issue_fire, ret_fire, out_fire;
  logic          gen_hold, has_room;
  logic [CW-1:0] in_use;
  logic [AW-1:0] gen_addr;
  fbr_mark_t     gen_mark, ret_mark;
  logic [MW-1:0] ret_mark_bits;
  logic          tag_empty, tag_full, buf_empty, buf_full;
  logic [BW-1:0] buf_head;

  assign mem_req    = has_room && (cfg_enable || gen_hold);
  assign issue_fire = mem_req && !mem_wait;
  assign ret_fire   = mem_rdvalid;
  assign out_fire   = out_valid && out_ready;
  assign mem_addr   = gen_addr;

  fbr_addr_gen #(.AW(AW), .LW(LW)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (mem_req),
    .wait_in   (mem_wait),
    .cfg_base  (cfg_base),
    .cfg_words (cfg_words),
    .addr      (gen_addr),
    .mark      (gen_mark),
    .hold      (gen_hold)
  );

  fbr_credit #(.DEPTH(DEPTH)) u_credit (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (issue_fire),
    .give  (out_fire),
    .room  (has_room),
    .level (in_use)
  );

  // markers of reads in flight, in issue order
  fbr_fifo #(.W(MW), .DEPTH(DEPTH)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (issue_fire),
    .din   (gen_mark),
    .pop   (ret_fire),
    .dout  (ret_mark_bits),
    .empty (tag_empty),
    .full  (tag_full)
  );
  assign ret_mark = fbr_mark_t'(ret_mark_bits);

  // returned words waiting for the consumer
  fbr_fifo #(.W(BW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ret_fire),
    .din   ({ret_mark, mem_rdata}),
    .pop   (out_fire),
    .dout  (buf_head),
    .empty (buf_empty),
    .full  (buf_full)
  );

  assign out_valid = !buf_empty;
  assign out_data  = buf_head[DW-1:0];
  assign out_sop   = buf_head[DW+1];
  assign out_eop   = buf_head[DW];

  // R1
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !gen_hold) |-> !mem_req);
  // R4
  return_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |-> !tag_empty);
  // R5
  no_issue_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_full |-> !issue_fire);
  // R5
  buffer_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> !ret_fire);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wait) |=> (mem_req && $stable(mem_addr)));
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

endmodule

// File: tb/fbr_reader_bench.sv
module fbr_reader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE     = 2;
  localparam int DEPTH      = 8;
  localparam int LAT        = 3;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_words = '0;
  logic        mem_req, mem_wait, mem_rdvalid;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata;
  logic        out_valid, out_ready, out_sop, out_eop;
  logic [63:0] out_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // stimulus modes
  bit wait_rand = 0, wait_force = 0, rdy_rand = 0, rdy_force = 1;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbr_reader #(.AW(32), .DW(64), .LW(16), .DEPTH(DEPTH)) u_fbr_reader (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
    .cfg_words(cfg_words), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wait(mem_wait), .mem_rdvalid(mem_rdvalid), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  function automatic logic [63:0] pattern(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // fixed-latency in-order memory model
  logic [LAT-1:0] pv;
  logic [31:0]    pa [LAT];
  int acc_cnt, req_cycles;

  always @(posedge clk) begin
    if (!rst_n) begin
      pv <= '0;
      acc_cnt <= 0;
      req_cycles <= 0;
    end else begin
      pv <= {pv[LAT-2:0], mem_req && !mem_wait};
      if (mem_req && !mem_wait) acc_cnt <= acc_cnt + 1;
      if (mem_req) req_cycles <= req_cycles + 1;
    end
    pa[0] <= mem_addr;
    for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
  end
  assign mem_rdvalid = pv[LAT-1];
  assign mem_rdata   = pattern(pa[LAT-1]);

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_wait  = wait_rand ? (lfsr[0] | lfsr[5]) : wait_force;
    out_ready = rdy_rand ? lfsr[3] : rdy_force;
  end

  // expected stream model, written from the requirements
  logic [31:0] tb_base = '0;
  logic [15:0] tb_len = '0;
  logic [31:0] m_base;
  int m_len, exp_idx, out_words;
  bit prev_hold, prev_stall;
  logic [31:0] prev_addr;
  logic [63:0] prev_data;

  always @(negedge clk) begin
    #SAMPLE;
    if (!rst_n) begin
      exp_idx = 0; out_words = 0; prev_hold = 0; prev_stall = 0;
    end else begin
      if (prev_hold)
        chk(mem_req && mem_addr == prev_addr, "R7 request held",
            {31'd0, mem_req, mem_addr}, {31'd0, 1'b1, prev_addr});
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8 output held",
            out_data, prev_data);
      if (out_valid && out_ready) begin
        logic [31:0] ea;
        if (exp_idx == 0) begin
          m_base = tb_base;
          m_len  = (tb_len == 0) ? 1 : int'(tb_len);
        end
        ea = m_base + 32'(exp_idx) * 32'd8;
        chk(out_data == pattern(ea), "R2/R4 word order", out_data, pattern(ea));
        chk({out_sop, out_eop} == {exp_idx == 0, exp_idx == m_len - 1},
            "R3 markers", {62'd0, out_sop, out_eop},
            {62'd0, exp_idx == 0, exp_idx == m_len - 1});
        exp_idx = (exp_idx == m_len - 1) ? 0 : exp_idx + 1;
        out_words++;
      end
      prev_hold  = mem_req && mem_wait;
      prev_addr  = mem_addr;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cfg_enable = 0;
    wait_rand = 0; wait_force = 0; rdy_rand = 0; rdy_force = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_cfg(input logic [31:0] b, input logic [15:0] n);
    tb_base = b; tb_len = n; cfg_base = b; cfg_words = n;
  endtask

  task automatic wait_words(input int n);
    int tgt = out_words + n;
    while (out_words < tgt) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    set_cfg(32'h0000_2000, 16'd4);
    #SAMPLE;
    chk(!out_valid, "R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    chk(!mem_req, "R1 mem_req after reset", {63'd0, mem_req}, 64'd0);
    repeat (20) @(negedge clk);
    chk(req_cycles == 0, "R1 no request while disabled", 64'(req_cycles), 64'd0);
  endtask

  task automatic t_basic();
    do_reset();
    set_cfg(32'h0000_1000, 16'd5);
    cfg_enable = 1;
    wait_words(12);
    #SAMPLE;
    chk(out_words >= 12, "R2 wrap stream length", 64'(out_words), 64'd12);
  endtask

  task automatic t_stalls();
    do_reset();
    set_cfg(32'h0004_0000, 16'd7);
    wait_rand = 1; rdy_rand = 1;
    cfg_enable = 1;
    wait_words(40);
    chk(out_words >= 40, "R4 words under stalls", 64'(out_words), 64'd40);
  endtask

  task automatic t_backpressure();
    do_reset();
    set_cfg(32'h0000_8000, 16'd6);
    rdy_force = 0;
    cfg_enable = 1;
    repeat (60) @(negedge clk);
    #SAMPLE;
    chk(acc_cnt == DEPTH, "R5 reads capped at depth", 64'(acc_cnt), 64'(DEPTH));
    chk(!mem_req, "R5 no request when full", {63'd0, mem_req}, 64'd0);
    chk(out_valid && out_data == pattern(32'h0000_8000), "R4 head word held",
        out_data, pattern(32'h0000_8000));
    @(negedge clk);
    rdy_force = 1;
    wait_words(20);
  endtask

  task automatic t_cfg_change();
    do_reset();
    set_cfg(32'h0010_0000, 16'd20);
    cfg_enable = 1;
    wait_words(6);
    set_cfg(32'h0020_0000, 16'd3);
    wait_words(14 + 9);
    chk(out_words >= 29, "R6 new frame reached", 64'(out_words), 64'd29);
  endtask

  task automatic t_zero_len();
    do_reset();
    set_cfg(32'h0000_0400, 16'd0);
    wait_rand = 1;
    cfg_enable = 1;
    wait_words(6);
    chk(out_words >= 6, "R10 single-word frames", 64'(out_words), 64'd6);
  endtask

  task automatic t_enable_drop();
    int saved;
    do_reset();
    set_cfg(32'h0000_3000, 16'd9);
    cfg_enable = 1;
    wait_words(5);
    cfg_enable = 0;
    #SAMPLE;
    saved = acc_cnt;
    repeat (30) @(negedge clk);
    #SAMPLE;
    chk(acc_cnt == saved, "R9 no reads while disabled", 64'(acc_cnt), 64'(saved));
    chk(out_words == acc_cnt, "R9 in-flight words delivered",
        64'(out_words), 64'(acc_cnt));
    chk(!out_valid, "R9 stream drained", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    cfg_enable = 1;
    wait_words(10);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_stalls();
    t_backpressure();
    t_cfg_change();
    t_zero_len();
    t_enable_drop();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule